// File: doc/BRIEF.md
# Multi-Master GPIO Pin Multiplexer

This block holds the control and data state for a bank of general-purpose pins. It also selects what each pin's pad output does. A pin can be owned by one of twelve peripheral functions. It can instead be run as processor-controlled I/O, and in that mode a per-pin owner field names which of four processor masters controls its data and direction. An open-drain option can be applied to any pin, whatever its source. The raw pad input goes through a two-flop synchronizer, and that synchronized level is readable by any processor or accelerator, whoever owns the pin's output.

Register accesses arrive on a single-cycle request port that carries a requester ID. The block applies a separate access rule to each register group. Only processors may touch the configuration group, and only processor 0 may change it. Processors and accelerators may use the data group, but only on the pins their owner field assigns to them. The output-latch read-back may be read by processors, accelerators and the host interface. Each request gets a registered response one cycle later, with read data and an error flag.

Top module: `gpio_mux_bank`

## Requirements
- R1: Each pin has a 4-bit source field at bits [4p+3:4p] of register 0. Value 0 selects processor I/O, so pad output = output latch bit and output enable = direction bit. Value k (1..12) selects peripheral k-1, whose data and enable are bits p*12+k-1 of the peripheral vectors. Values 13..15 disable the pad output.
- R2: Register 1 holds a 2-bit owner field per pin at bits [2p+1:2p]. A write to the direction (3), data (4), set (5), clear (6) or toggle (7) register changes only the pins whose owner equals the requester's ID modulo 4. Reading the direction register returns only those owned bits.
- R3: Register 4 reads the synchronized pad level of every pin, for any processor or accelerator, whoever owns the pin.
- R4: Register 2 bits [7:0] select open drain per pin, and bits [15:8] drive the pull-enable outputs. In open-drain mode, a source data value of 1 turns the output enable off, and a source data value of 0 with the enable on drives the pad low. The pad data output is then always 0.
- R5: Requesters 1..3 may read registers 0..2. Their writes there are ignored without error.
- R6: Requesters 4..7 (accelerators), 8 (DMA) and 9..15 are denied registers 0..2. A denied access returns zero data with the error flag set.
- R7: Accelerator ID 4+m has the same pin ownership as processor m in registers 3..7. DMA and IDs 9..15 are denied registers 3..7.
- R8: Register 8 returns the output latch to processors, accelerators and the host (ID 9). DMA and IDs 10..15 are denied.
- R9: In set, clear and toggle writes, a 1 bit sets, clears or inverts the matching owned latch bit, and a 0 bit leaves that bit unchanged. These three registers read as zero without error.
- R10: The pin-level output and register 4 show the pad input exactly two clock edges after it is applied.
- R11: Every request gets a response one cycle later. Addresses 9..15 and any write to register 8 return an error and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | 4 | Requester ID (0..3 processors, 4..7 accelerators, 8 DMA, 9 host) |
| req_addr | input | 4 | Register index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_err | output | 1 | Access denied or unmapped |
| rsp_rdata | output | 32 | Read data, zero on error or write |
| periph_do | input | 96 | Peripheral data, pin-major, 12 per pin |
| periph_oe | input | 96 | Peripheral output enable, same layout |
| pad_di | input | 8 | Raw pad input levels |
| pad_do | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enable |
| pad_pull | output | 8 | Pull-enable control per pin |
| pin_level | output | 8 | Synchronized pad level |

## Verification
The assertions watch, on every cycle, the one-cycle response timing, zero data on every error, the two-edge input latency, the rule that an open-drain pin never drives high, the rule that a disabled source never enables the pad, and the guards that keep non-primary configuration writes and DMA data writes from changing any state. Only the bench scenarios can show the data paths in full. These include which peripheral bit reaches which pad, that pin ownership confines writes to owned bits, the set/clear/toggle arithmetic, and the read permissions of each requester class.

// File: rtl/gpio_mux_pkg.sv
// Shared encodings for the GPIO pin multiplexer.
// Assumes register indices fit in 4 bits.
package gpio_mux_pkg;
    typedef enum logic [3:0] {
        A_MUX  = 4'd0,
        A_MSEL = 4'd1,
        A_OPT  = 4'd2,
        A_DIR  = 4'd3,
        A_DAT  = 4'd4,
        A_SET  = 4'd5,
        A_CLR  = 4'd6,
        A_TOG  = 4'd7,
        A_RDBK = 4'd8
    } reg_addr_e;

    typedef enum logic [2:0] {
        CLS_CPU,
        CLS_ACC,
        CLS_DMA,
        CLS_HOST,
        CLS_NONE
    } req_class_e;
endpackage

// File: rtl/gpio_access.sv
// Access arbiter: classifies the requester and decides grant/error per register group.
// Assumes IDs 0..M-1 processors, M..2M-1 accelerators, 2M DMA, 2M+1 host.
module gpio_access
    import gpio_mux_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int ID_W        = 4
) (
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [ID_W-1:0] req_id,
    input  logic [3:0]      req_addr,
    output logic            acc_ok,
    output logic            acc_err,
    output logic            cfg_commit,
    output logic            data_commit
);
    localparam logic [ID_W-1:0] ID_ACC_END = ID_W'(2 * NUM_MASTERS);
    localparam logic [ID_W-1:0] ID_DMA     = ID_W'(2 * NUM_MASTERS);
    localparam logic [ID_W-1:0] ID_HOST    = ID_W'(2 * NUM_MASTERS + 1);

    req_class_e cls;
    logic       hit_ok, is_cfg, is_data;

    // Classify the requester by ID range.
    always_comb begin
        if (req_id < ID_W'(NUM_MASTERS))  cls = CLS_CPU;
        else if (req_id < ID_ACC_END)     cls = CLS_ACC;
        else if (req_id == ID_DMA)        cls = CLS_DMA;
        else if (req_id == ID_HOST)       cls = CLS_HOST;
        else                              cls = CLS_NONE;
    end

    // Apply each register group's rule for the requester class.
    always_comb begin
        is_cfg  = 1'b0;
        is_data = 1'b0;
        hit_ok  = 1'b0;
        case (req_addr)
            A_MUX, A_MSEL, A_OPT: begin
                is_cfg = 1'b1;
                hit_ok = (cls == CLS_CPU);
            end
            A_DIR, A_DAT, A_SET, A_CLR, A_TOG: begin
                is_data = 1'b1;
                hit_ok  = (cls == CLS_CPU) || (cls == CLS_ACC);
            end
            A_RDBK:  hit_ok = !req_write &&
                              ((cls == CLS_CPU) || (cls == CLS_ACC) || (cls == CLS_HOST));
            default: hit_ok = 1'b0;
        endcase
    end

    assign acc_ok      = req_valid && hit_ok;
    assign acc_err     = req_valid && !hit_ok;
    assign cfg_commit  = acc_ok && req_write && is_cfg && (req_id == '0);
    assign data_commit = acc_ok && req_write && is_data;
endmodule

// File: rtl/gpio_pin_out.sv
// Per-pin output selector: picks processor I/O or one peripheral, then applies open drain.
// Assumes source field 0 = processor I/O, 1..NUM_PERIPH = peripheral, others = off.
module gpio_pin_out #(
    parameter int NUM_PERIPH = 12,
    parameter int SEL_W      = 4
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic                  od_en,
    input  logic                  gpio_do,
    input  logic                  gpio_oe,
    input  logic [NUM_PERIPH-1:0] per_do,
    input  logic [NUM_PERIPH-1:0] per_oe,
    output logic                  pad_do,
    output logic                  pad_oe
);
    logic             src_do, src_oe;
    logic [SEL_W-1:0] idx;

    assign idx = sel - SEL_W'(1);

    // Select the source driving this pin.
    always_comb begin
        if (sel == '0) begin
            src_do = gpio_do;
            src_oe = gpio_oe;
        end else if (sel <= SEL_W'(NUM_PERIPH)) begin
            src_do = per_do[idx];
            src_oe = per_oe[idx];
        end else begin
            src_do = 1'b0;
            src_oe = 1'b0;
        end
    end

    // Open drain: a 1 releases the pad, a 0 pulls it low.
    always_comb begin
        if (od_en) begin
            pad_do = 1'b0;
            pad_oe = src_oe && !src_do;
        end else begin
            pad_do = src_do;
            pad_oe = src_oe;
        end
    end
endmodule

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for the raw pad inputs.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the pad level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_mux_bank.sv
// GPIO bank top: configuration and data registers, per-requester access rules,
// per-pin output selection and a synchronized input path.
// Assumes NUM_PINS*SEL_W <= DW and 2*NUM_PINS <= DW; one request per cycle.
module gpio_mux_bank
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int NUM_PERIPH  = 12,
    parameter int NUM_MASTERS = 4,
    parameter int ID_W        = 4,
    parameter int DW          = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ID_W-1:0]                req_id,
    input  logic [3:0]                     req_addr,
    input  logic [DW-1:0]                  req_wdata,
    output logic                           rsp_valid,
    output logic                           rsp_err,
    output logic [DW-1:0]                  rsp_rdata,
    input  logic [NUM_PINS*NUM_PERIPH-1:0] periph_do,
    input  logic [NUM_PINS*NUM_PERIPH-1:0] periph_oe,
    input  logic [NUM_PINS-1:0]            pad_di,
    output logic [NUM_PINS-1:0]            pad_do,
    output logic [NUM_PINS-1:0]            pad_oe,
    output logic [NUM_PINS-1:0]            pad_pull,
    output logic [NUM_PINS-1:0]            pin_level
);
    localparam int SEL_W  = $clog2(NUM_PERIPH + 1);
    localparam int MSEL_W = $clog2(NUM_MASTERS);
    localparam int MUX_W  = NUM_PINS * SEL_W;
    localparam int OWN_W  = NUM_PINS * MSEL_W;

    logic [MUX_W-1:0]    mux_q;
    logic [OWN_W-1:0]    msel_q;
    logic [NUM_PINS-1:0] od_q, pull_q, dir_q, dat_q;
    logic [NUM_PINS-1:0] own, wd;
    logic [DW-1:0]       rd_val;
    logic                acc_ok, acc_err, cfg_commit, data_commit;

    assign wd       = req_wdata[NUM_PINS-1:0];
    assign pad_pull = pull_q;

    gpio_access #(.NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W)) access_i (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_id     (req_id),
        .req_addr   (req_addr),
        .acc_ok     (acc_ok),
        .acc_err    (acc_err),
        .cfg_commit (cfg_commit),
        .data_commit(data_commit)
    );

    gpio_sync #(.W(NUM_PINS)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_di),
        .q    (pin_level)
    );

    // Per pin: ownership match and output selection.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign own[p] = (msel_q[p*MSEL_W +: MSEL_W] == req_id[MSEL_W-1:0]);

        gpio_pin_out #(.NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)) out_i (
            .sel    (mux_q[p*SEL_W +: SEL_W]),
            .od_en  (od_q[p]),
            .gpio_do(dat_q[p]),
            .gpio_oe(dir_q[p]),
            .per_do (periph_do[p*NUM_PERIPH +: NUM_PERIPH]),
            .per_oe (periph_oe[p*NUM_PERIPH +: NUM_PERIPH]),
            .pad_do (pad_do[p]),
            .pad_oe (pad_oe[p])
        );
    end

    // Configuration registers: only the primary processor commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q  <= '0;
            msel_q <= '0;
            od_q   <= '0;
            pull_q <= '0;
        end else if (cfg_commit) begin
            case (req_addr)
                A_MUX:   mux_q <= req_wdata[MUX_W-1:0];
                A_MSEL:  msel_q <= req_wdata[OWN_W-1:0];
                A_OPT: begin
                    od_q   <= req_wdata[NUM_PINS-1:0];
                    pull_q <= req_wdata[2*NUM_PINS-1:NUM_PINS];
                end
                default: ;
            endcase
        end
    end

    // Data registers: writes touch only the requester's own pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (data_commit) begin
            case (req_addr)
                A_DIR:   dir_q <= (dir_q & ~own) | (wd & own);
                A_DAT:   dat_q <= (dat_q & ~own) | (wd & own);
                A_SET:   dat_q <= dat_q | (wd & own);
                A_CLR:   dat_q <= dat_q & ~(wd & own);
                A_TOG:   dat_q <= dat_q ^ (wd & own);
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (req_addr)
            A_MUX:   rd_val = DW'(mux_q);
            A_MSEL:  rd_val = DW'(msel_q);
            A_OPT:   rd_val = DW'({pull_q, od_q});
            A_DIR:   rd_val = DW'(dir_q & own);
            A_DAT:   rd_val = DW'(pin_level);
            A_RDBK:  rd_val = DW'(dat_q);
            default: rd_val = '0;
        endcase
    end

    // Registered response one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_err;
            rsp_rdata <= (acc_ok && !req_write) ? rd_val : '0;
        end
    end
endmodule

// File: rtl/gpio_mux_bank_sva.sv
// Checker for gpio_mux_bank, bound into every instance.
// Assumes the default requester ID layout (DMA = 2*NUM_MASTERS).
module gpio_mux_bank_sva #(
    parameter int NUM_PINS    = 8,
    parameter int NUM_MASTERS = 4,
    parameter int ID_W        = 4,
    parameter int DW          = 32,
    parameter int MUX_W       = 32,
    parameter int SEL_W       = 4,
    parameter int NUM_PERIPH  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [ID_W-1:0]     req_id,
    input logic [3:0]          req_addr,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic [DW-1:0]       rsp_rdata,
    input logic [NUM_PINS-1:0] pad_di,
    input logic [NUM_PINS-1:0] pin_level,
    input logic [NUM_PINS-1:0] pad_do,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] od_q,
    input logic [MUX_W-1:0]    mux_q,
    input logic [NUM_PINS-1:0] dat_q
);
    logic [1:0] cyc;

    // Count edges since reset, saturating, to guard the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    assert_rsp_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_err_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    assert_sync_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (pin_level == $past(pad_di, 2)));

    assert_cfg_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_id != '0) && (req_addr <= 4'd2)) |=> $stable(mux_q));

    assert_dma_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_id == ID_W'(2 * NUM_MASTERS)) &&
         (req_addr >= 4'd3) && (req_addr <= 4'd7)) |=> $stable(dat_q));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            od_q[p] |-> !pad_do[p]);

        assert_off_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (mux_q[p*SEL_W +: SEL_W] > SEL_W'(NUM_PERIPH)) |-> !pad_oe[p]);
    end
endmodule

bind gpio_mux_bank gpio_mux_bank_sva #(
    .NUM_PINS(NUM_PINS), .NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W), .DW(DW),
    .MUX_W(MUX_W), .SEL_W(SEL_W), .NUM_PERIPH(NUM_PERIPH)
) sva_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_id(req_id), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .pad_di(pad_di), .pin_level(pin_level), .pad_do(pad_do),
    .pad_oe(pad_oe), .od_q(od_q), .mux_q(mux_q), .dat_q(dat_q)
);

// File: tb/gpio_mux_bank_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected responses; the monitor compares them.
module gpio_mux_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_id = '0, req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [95:0] periph_do = '0, periph_oe = '0;
    logic [7:0]  pad_di = '0;
    logic [7:0]  pad_do, pad_oe, pad_pull, pin_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    gpio_mux_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .periph_do(periph_do), .periph_oe(periph_oe), .pad_di(pad_di),
        .pad_do(pad_do), .pad_oe(pad_oe), .pad_pull(pad_pull), .pin_level(pin_level)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one request, expected response pushed to the scoreboard.
    task automatic bus(input bit wr, input int id, input int addr, input logic [31:0] wd,
                       input logic [31:0] ed, input bit ee, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_id    = id[3:0];
        req_addr  = addr[3:0];
        req_wdata = wd;
        sb.push_back('{ed, ee, tag});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the oldest expectation.
    always begin
        @(posedge clk);
        #1;
        if (rsp_valid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({31'd0, rsp_err}, {31'd0, e.err}, {e.tag, " err"});
                chk(rsp_rdata, e.data, {e.tag, " data"});
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk({24'd0, pad_oe}, 32'h0, "R1 reset pad_oe");
        bus(0, 0, 0, 0, 32'h0, 0, "R1 reset mux");

        // R1: pin1 -> peripheral 2, pin2 -> disabled code 14
        periph_do[14] = 1'b1;
        periph_oe[14] = 1'b1;
        bus(1, 0, 0, 32'h0000_0E30, 0, 0, "R1 write mux");
        chk({31'd0, pad_do[1]}, 1, "R1 periph do");
        chk({31'd0, pad_oe[1]}, 1, "R1 periph oe");
        chk({31'd0, pad_oe[2]}, 0, "R1 disabled oe");
        bus(0, 2, 0, 0, 32'h0000_0E30, 0, "R5 cpu2 reads mux");

        // R5: non-primary config write ignored
        bus(1, 1, 0, 32'hFFFF_FFFF, 0, 0, "R5 cpu1 write mux");
        bus(0, 0, 0, 0, 32'h0000_0E30, 0, "R5 mux unchanged");

        // R6: non-processor config access denied
        bus(0, 4, 0, 0, 0, 1, "R6 acc read mux");
        bus(1, 8, 2, 32'hFF, 0, 1, "R6 dma write opt");
        bus(0, 9, 1, 0, 0, 1, "R6 host read msel");
        bus(0, 0, 2, 0, 0, 0, "R6 opt unchanged");

        // R2: pin0 owned by master 2
        bus(1, 0, 1, 32'h0000_0002, 0, 0, "R2 write msel");
        bus(1, 0, 3, 32'hFF, 0, 0, "R2 cpu0 dir");
        bus(1, 0, 4, 32'hFF, 0, 0, "R2 cpu0 dat");
        bus(0, 0, 8, 0, 32'h0000_00FE, 0, "R2 rdbk after cpu0");
        chk({31'd0, pad_oe[0]}, 0, "R2 pin0 not driven");
        bus(1, 2, 3, 32'h01, 0, 0, "R2 cpu2 dir");
        bus(1, 2, 4, 32'h00, 0, 0, "R2 cpu2 dat");
        bus(0, 2, 3, 0, 32'h0000_0001, 0, "R2 cpu2 dir own bits");
        chk({30'd0, pad_oe[0], pad_do[0]}, 32'h2, "R2 pin0 driven low");
        chk({30'd0, pad_oe[3], pad_do[3]}, 32'h3, "R2 pin3 driven high");

        // R7: accelerator ownership follows its processor
        bus(1, 6, 5, 32'h03, 0, 0, "R7 acc6 set");
        bus(0, 0, 8, 0, 32'h0000_00FF, 0, "R7 rdbk after acc6");
        bus(1, 5, 6, 32'hFF, 0, 0, "R7 acc5 clear none owned");
        bus(1, 8, 6, 32'hFF, 0, 1, "R7 dma clear denied");
        bus(0, 9, 8, 0, 32'h0000_00FF, 0, "R8 host rdbk");

        // R9: set/clear/toggle semantics
        bus(1, 0, 6, 32'h0C, 0, 0, "R9 clear");
        bus(1, 0, 7, 32'h31, 0, 0, "R9 toggle");
        bus(0, 0, 8, 0, 32'h0000_00C3, 0, "R9 rdbk");
        bus(0, 0, 5, 0, 32'h0, 0, "R9 set reads zero");
        bus(1, 0, 5, 32'h10, 0, 0, "R9 set");
        bus(0, 0, 8, 0, 32'h0000_00D3, 0, "R9 rdbk after set");

        // R4: open drain on pins 1,3,4; pull on pin 3
        bus(1, 0, 2, 32'h0000_081A, 0, 0, "R4 write opt");
        chk({30'd0, pad_oe[3], pad_do[3]}, 32'h2, "R4 od pin3 low");
        chk({30'd0, pad_oe[4], pad_do[4]}, 32'h0, "R4 od pin4 released");
        chk({30'd0, pad_oe[1], pad_do[1]}, 32'h0, "R4 od periph released");
        chk({24'd0, pad_pull}, 32'h08, "R4 pull");
        @(negedge clk);
        periph_do[14] = 1'b0;
        #1;
        chk({30'd0, pad_oe[1], pad_do[1]}, 32'h2, "R4 od periph low");

        // R10 and R3: synchronizer latency and level read
        @(negedge clk);
        pad_di = 8'hA5;
        @(negedge clk);
        chk({24'd0, pin_level}, 32'h0, "R10 one edge");
        @(negedge clk);
        chk({24'd0, pin_level}, 32'hA5, "R10 two edges");
        bus(0, 3, 4, 0, 32'h0000_00A5, 0, "R3 cpu3 reads level");
        bus(0, 7, 4, 0, 32'h0000_00A5, 0, "R3 acc reads level");
        bus(0, 8, 8, 0, 0, 1, "R8 dma rdbk denied");
        bus(0, 8, 4, 0, 0, 1, "R7 dma dat denied");

        // R11: unmapped and write to read-back
        bus(0, 0, 12, 0, 0, 1, "R11 unmapped");
        bus(1, 0, 8, 32'h0, 0, 1, "R11 rdbk write");
        bus(0, 0, 8, 0, 32'h0000_00D3, 0, "R11 rdbk unchanged");

        repeat (4) @(negedge clk);
        chk(sb.size(), 0, "R11 all responses seen");
        finish_run();
    end
endmodule